// File: doc/BRIEF.md
# I2C Target Address Matcher

This block is the target side of an I2C controller. It watches synchronised copies of SCL and SDA and detects START and STOP. After each START it shifts in the address byte. That byte is compared against a programmable 7-bit own address and, when enabled, against the all-zero general-call address. On a hit it acknowledges, raises a new-match event, and records two things: which of the two kinds matched, and the transfer direction.

Data then moves through a one-byte handshake. A received byte is acknowledged and presented on `rx_data`. A byte to transmit is supplied through `tx_data`/`tx_load`. The `sdast` output says software attention is needed, and SCL is held low until that attention arrives. A master NACK after a transmitted byte raises a sticky flag. So does a STOP that closes a transaction this target took part in. A repeated START inside such a transaction starts a fresh address match, and the direction may change.

Top module: `i2c_tgt_matcher`

## Requirements
- R1: After reset the flags `new_match`, `own_hit`, `gcall_hit`, `stop_seen`, `nack_seen`, `xmit`, `irq`, `sdast`, `scl_oe` and `sda_oe` are all 0.
- R2: With `cfg_tgt_en`=1 and a non-zero `cfg_own_addr`, an address byte whose upper 7 bits (first 7 bits on the wire, MSB first) equal `cfg_own_addr` is acknowledged (SDA low in the 9th bit). It also sets `new_match` and `own_hit`, and `xmit` takes the byte's last bit (1 = target transmits, 0 = target receives).
- R3: An address byte that matches nothing is not acknowledged and changes no flag. With `cfg_tgt_en`=0 the own address never matches.
- R4: The byte 0x00 matches as a general call only when `cfg_gc_en`=1. It then sets `gcall_hit` and `new_match`, forces `xmit`=0 and is acknowledged. The byte 0x01 never matches as a general call.
- R5: `new_match`, `own_hit` and `gcall_hit` are sticky and clear on a `clr_match` pulse. A set in the same cycle wins over the clear. `irq` is 1 exactly while `new_match` and `cfg_nm_ie` are both 1.
- R6: In receive mode each 8-bit data byte, sent MSB first, is acknowledged and appears on `rx_data` with `sdast`=1. After the ACK bit SCL is held low (`scl_oe`=1) until `rx_take` is pulsed, and the pulse drops `sdast`.
- R7: In transmit mode the target holds SCL low with `sdast`=1 until `tx_load` supplies a byte. That byte is then driven MSB first on SDA.
- R8: A master NACK (SDA high in the 9th bit) after a transmitted byte sets `nack_seen`, which clears on `clr_nack`. The target then stops driving SDA.
- R9: A STOP (SDA rising while SCL is high) that ends a transaction this target acknowledged sets `stop_seen`, which clears on `clr_stop`. A STOP after an unmatched address leaves it at 0.
- R10: A repeated START inside an acknowledged transaction re-runs address matching without setting `stop_seen`. A new hit sets `new_match` again, and `xmit` follows the new direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (ACK or data 0) |
| cfg_own_addr | input | 7 | Own 7-bit target address |
| cfg_tgt_en | input | 1 | Own-address matching enable |
| cfg_gc_en | input | 1 | General-call matching enable |
| cfg_nm_ie | input | 1 | New-match interrupt enable |
| tx_data | input | 8 | Byte to transmit |
| tx_load | input | 1 | Pulse: `tx_data` is valid |
| rx_data | output | 8 | Last received byte |
| rx_take | input | 1 | Pulse: `rx_data` has been consumed |
| sdast | output | 1 | A byte is waiting to be read or is needed to send |
| xmit | output | 1 | Direction of the current match, 1 = target transmits |
| new_match | output | 1 | Sticky new-match event |
| own_hit | output | 1 | Sticky own-address match |
| gcall_hit | output | 1 | Sticky general-call match |
| stop_seen | output | 1 | Sticky STOP after an addressed transaction |
| nack_seen | output | 1 | Sticky master NACK after a transmitted byte |
| irq | output | 1 | New-match interrupt |
| clr_match | input | 1 | Clear `new_match`, `own_hit`, `gcall_hit` |
| clr_stop | input | 1 | Clear `stop_seen` |
| clr_nack | input | 1 | Clear `nack_seen` |

## Verification
The bench builds the block with its defaults: two synchroniser stages and general-call support present. This means the general-call path, both enable gates and the 0x01 near-miss can all be reached. The bus half-bit of ten clocks is much longer than the three-cycle synchroniser and edge-detect latency. As a result, ACK, data drive and clock stretching all settle inside one SCL phase and can be sampled at fixed points. The model also includes a wired-AND bus. With it, stretching shows up as the master waiting on SCL, and a repeated START can be driven from the receive and transmit states alike.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   typedef enum logic [3:0] {
      TS_IDLE,
      TS_ADDR,
      TS_AACK,
      TS_RX,
      TS_RXACK,
      TS_TXLD,
      TS_TXBIT,
      TS_TXACK,
      TS_DONE
   } tgt_state_t;

   localparam int FL_NM    = 0;
   localparam int FL_OWN   = 1;
   localparam int FL_GC    = 2;
   localparam int FL_STOP  = 3;
   localparam int FL_NACK  = 4;
   localparam int FL_COUNT = 5;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_tgt_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-1:0], line_i};
   end

   assign lvl_o  = chain_q[STAGES-1];
   assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
   assign fall_o = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/i2c_tgt_addr_cmp.sv
module i2c_tgt_addr_cmp #(
   parameter int ADDR_W     = 7,
   parameter bit GC_SUPPORT = 1'b1,
   localparam int BYTE_W    = ADDR_W + 1
) (
   input  logic [BYTE_W-1:0] addr_byte_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              tgt_en_i,
   input  logic              gc_en_i,
   output logic              own_hit_o,
   output logic              gc_hit_o
);
   generate
      if (ADDR_W != 7) begin : g_bad_width
         $error("i2c_tgt_addr_cmp: only 7-bit addressing is supported");
      end
   endgenerate

   assign own_hit_o = tgt_en_i && (own_addr_i != '0) &&
                      (addr_byte_i[BYTE_W-1:1] == own_addr_i);

   generate
      if (GC_SUPPORT) begin : g_gc
         assign gc_hit_o = gc_en_i && (addr_byte_i == '0);
      end else begin : g_no_gc
         logic unused_gc;
         assign unused_gc = gc_en_i;
         assign gc_hit_o  = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/i2c_tgt_flags.sv
module i2c_tgt_flags #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("i2c_tgt_flags: N must be positive");
      end
   endgenerate

   logic [N-1:0] flag_q;

   for (genvar k = 0; k < N; k++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flag_q[k] <= 1'b0;
         else if (set_i[k]) flag_q[k] <= 1'b1;
         else if (clr_i[k]) flag_q[k] <= 1'b0;
      end

      // R5
      w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[k] && !set_i[k]) |=> !flag_q[k]);
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/i2c_tgt_matcher.sv
module i2c_tgt_matcher
   import i2c_tgt_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2,
   parameter bit GC_SUPPORT  = 1'b1,
   localparam int BYTE_W     = ADDR_W + 1,
   localparam int CNT_W      = $clog2(BYTE_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe,
   input  logic [ADDR_W-1:0] cfg_own_addr,
   input  logic              cfg_tgt_en,
   input  logic              cfg_gc_en,
   input  logic              cfg_nm_ie,
   input  logic [BYTE_W-1:0] tx_data,
   input  logic              tx_load,
   output logic [BYTE_W-1:0] rx_data,
   input  logic              rx_take,
   output logic              sdast,
   output logic              xmit,
   output logic              new_match,
   output logic              own_hit,
   output logic              gcall_hit,
   output logic              stop_seen,
   output logic              nack_seen,
   output logic              irq,
   input  logic              clr_match,
   input  logic              clr_stop,
   input  logic              clr_nack
);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

   // line conditioning
   logic scl_lvl, scl_rise, scl_fall;
   logic sda_lvl, sda_rise, sda_fall;

   i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i),
      .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

   i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i),
      .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

   logic start_det, stop_det;
   assign start_det = scl_lvl && !scl_rise && sda_fall;
   assign stop_det  = scl_lvl && !scl_rise && sda_rise;

   // engine state
   tgt_state_t        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] sh_q;
   logic [BYTE_W-1:0] rx_q;
   logic [BYTE_W-1:0] tx_q;
   logic              rx_full_q, tx_full_q;
   logic              engaged_q, xmit_q, sda_oe_q;

   // address compare
   logic own_c, gc_c;
   i2c_tgt_addr_cmp #(.ADDR_W(ADDR_W), .GC_SUPPORT(GC_SUPPORT)) u_cmp (
      .addr_byte_i(sh_q), .own_addr_i(cfg_own_addr),
      .tgt_en_i(cfg_tgt_en), .gc_en_i(cfg_gc_en),
      .own_hit_o(own_c), .gc_hit_o(gc_c));

   // event decode
   logic quiet, addr_done, match_now, nack_now, stop_now, tx_consume;
   assign quiet      = !start_det && !stop_det;
   assign addr_done  = quiet && (state_q == TS_ADDR) && scl_fall && (cnt_q == FULL_CNT);
   assign match_now  = addr_done && (own_c || gc_c);
   assign nack_now   = quiet && (state_q == TS_TXACK) && scl_fall && sh_q[0];
   assign stop_now   = stop_det && engaged_q;
   assign tx_consume = quiet && (state_q == TS_TXLD) && tx_full_q;

   // sticky flags
   logic [FL_COUNT-1:0] fl_set, fl_clr, fl_q;

   always_comb begin
      fl_set          = '0;
      fl_set[FL_NM]   = match_now;
      fl_set[FL_OWN]  = match_now && own_c;
      fl_set[FL_GC]   = match_now && !own_c;
      fl_set[FL_STOP] = stop_now;
      fl_set[FL_NACK] = nack_now;
      fl_clr          = '0;
      fl_clr[FL_NM]   = clr_match;
      fl_clr[FL_OWN]  = clr_match;
      fl_clr[FL_GC]   = clr_match;
      fl_clr[FL_STOP] = clr_stop;
      fl_clr[FL_NACK] = clr_nack;
   end

   i2c_tgt_flags #(.N(FL_COUNT)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_i(fl_set), .clr_i(fl_clr), .flag_o(fl_q));

   // data handshake buffers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q      <= '0;
         tx_full_q <= 1'b0;
      end else if (tx_consume) begin
         tx_full_q <= 1'b0;
      end else if (tx_load) begin
         tx_q      <= tx_data;
         tx_full_q <= 1'b1;
      end
   end

   logic rx_store;
   assign rx_store = quiet && (state_q == TS_RX) && scl_fall && (cnt_q == FULL_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q      <= '0;
         rx_full_q <= 1'b0;
      end else if (rx_store) begin
         rx_q      <= sh_q;
         rx_full_q <= 1'b1;
      end else if (rx_take) begin
         rx_full_q <= 1'b0;
      end
   end

   // protocol engine
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= TS_IDLE;
         cnt_q     <= '0;
         sh_q      <= '0;
         engaged_q <= 1'b0;
         xmit_q    <= 1'b0;
         sda_oe_q  <= 1'b0;
      end else if (start_det) begin
         state_q  <= TS_ADDR;
         cnt_q    <= '0;
         sda_oe_q <= 1'b0;
      end else if (stop_det) begin
         state_q   <= TS_IDLE;
         engaged_q <= 1'b0;
         sda_oe_q  <= 1'b0;
      end else begin
         unique case (state_q)
            TS_ADDR: begin
               if (scl_rise) begin
                  sh_q  <= {sh_q[BYTE_W-2:0], sda_lvl};
                  cnt_q <= cnt_q + 1'b1;
               end else if (addr_done) begin
                  if (match_now) begin
                     state_q   <= TS_AACK;
                     engaged_q <= 1'b1;
                     sda_oe_q  <= 1'b1;
                     xmit_q    <= own_c ? sh_q[0] : 1'b0;
                  end else begin
                     state_q   <= TS_IDLE;
                     engaged_q <= 1'b0;
                  end
               end
            end
            TS_AACK: begin
               if (scl_fall) begin
                  sda_oe_q <= 1'b0;
                  cnt_q    <= '0;
                  state_q  <= xmit_q ? TS_TXLD : TS_RX;
               end
            end
            TS_RX: begin
               if (scl_rise) begin
                  sh_q  <= {sh_q[BYTE_W-2:0], sda_lvl};
                  cnt_q <= cnt_q + 1'b1;
               end else if (rx_store) begin
                  sda_oe_q <= 1'b1;
                  state_q  <= TS_RXACK;
               end
            end
            TS_RXACK: begin
               if (scl_fall) begin
                  sda_oe_q <= 1'b0;
                  cnt_q    <= '0;
                  state_q  <= TS_RX;
               end
            end
            TS_TXLD: begin
               if (tx_consume) begin
                  sh_q     <= tx_q;
                  sda_oe_q <= ~tx_q[BYTE_W-1];
                  cnt_q    <= '0;
                  state_q  <= TS_TXBIT;
               end
            end
            TS_TXBIT: begin
               if (scl_fall) begin
                  if (cnt_q == LAST_BIT) begin
                     sda_oe_q <= 1'b0;
                     state_q  <= TS_TXACK;
                  end else begin
                     sh_q     <= {sh_q[BYTE_W-2:0], 1'b0};
                     sda_oe_q <= ~sh_q[BYTE_W-2];
                     cnt_q    <= cnt_q + 1'b1;
                  end
               end
            end
            TS_TXACK: begin
               if (scl_rise) begin
                  sh_q[0] <= sda_lvl;
               end else if (scl_fall) begin
                  state_q <= sh_q[0] ? TS_DONE : TS_TXLD;
               end
            end
            default: ;
         endcase
      end
   end

   // outputs
   logic tx_need;
   assign tx_need   = (state_q == TS_TXLD) && !tx_full_q;
   assign sdast     = rx_full_q || tx_need;
   assign scl_oe    = tx_need || ((state_q == TS_RX) && (cnt_q == '0) && rx_full_q);
   assign sda_oe    = sda_oe_q;
   assign rx_data   = rx_q;
   assign xmit      = xmit_q;
   assign new_match = fl_q[FL_NM];
   assign own_hit   = fl_q[FL_OWN];
   assign gcall_hit = fl_q[FL_GC];
   assign stop_seen = fl_q[FL_STOP];
   assign nack_seen = fl_q[FL_NACK];
   assign irq       = fl_q[FL_NM] && cfg_nm_ie;

   // R4
   gc_recv_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gcall_hit) |-> !xmit);

   // R9
   stop_needs_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stop_seen) |-> $past(engaged_q));

   // R6
   stretch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scl_oe |-> sdast);

   // R2
   drive_when_engaged_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> engaged_q);

   // R5
   match_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(new_match) |-> (own_hit || gcall_hit));
endmodule

// File: tb/tb_i2c_tgt_matcher.sv
module tb_i2c_tgt_matcher;
   localparam int CLK_PERIOD = 10;
   localparam int HB         = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic       scl_m = 1'b1, sda_m = 1'b1;
   logic       scl_oe, sda_oe;
   logic       scl_line, sda_line;
   logic [6:0] own = 7'h5A;
   logic       tgt_en = 1'b1, gc_en = 1'b1, nm_ie = 1'b1;
   logic [7:0] tx_data = '0;
   logic       tx_load = 1'b0, rx_take = 1'b0;
   logic [7:0] rx_data;
   logic       sdast, xmit, new_match, own_hit, gcall_hit, stop_seen, nack_seen, irq;
   logic       clr_match = 1'b0, clr_stop = 1'b0, clr_nack = 1'b0;

   assign scl_line = scl_m & ~scl_oe;
   assign sda_line = sda_m & ~sda_oe;

   i2c_tgt_matcher dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .cfg_own_addr(own),
      .cfg_tgt_en(tgt_en), .cfg_gc_en(gc_en), .cfg_nm_ie(nm_ie),
      .tx_data(tx_data), .tx_load(tx_load), .rx_data(rx_data),
      .rx_take(rx_take), .sdast(sdast), .xmit(xmit),
      .new_match(new_match), .own_hit(own_hit), .gcall_hit(gcall_hit),
      .stop_seen(stop_seen), .nack_seen(nack_seen), .irq(irq),
      .clr_match(clr_match), .clr_stop(clr_stop), .clr_nack(clr_nack));

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // behavioural expectation state
   bit e_nm, e_own, e_gc, e_stop, e_nack, e_xmit, e_engaged;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_flags(input string req);
      chk(req, "new_match", int'(new_match), int'(e_nm));
      chk(req, "own_hit",   int'(own_hit),   int'(e_own));
      chk(req, "gcall_hit", int'(gcall_hit), int'(e_gc));
      chk(req, "stop_seen", int'(stop_seen), int'(e_stop));
      chk(req, "nack_seen", int'(nack_seen), int'(e_nack));
      chk(req, "irq",       int'(irq),       int'(e_nm & nm_ie));
      if (e_nm) chk(req, "xmit", int'(xmit), int'(e_xmit));
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_x(input logic b, output logic s);
      sda_m = b;
      wait_clk(HB);
      scl_m = 1'b1;
      do @(negedge clk); while (!scl_line);
      wait_clk(HB);
      s = sda_line;
      scl_m = 1'b0;
      wait_clk(HB/2);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl_m = 1'b1;
      wait_clk(HB);
      sda_m = 1'b0;
      wait_clk(HB);
      scl_m = 1'b0;
      wait_clk(HB/2);
   endtask

   task automatic bus_rep_start();
      sda_m = 1'b1;
      wait_clk(HB);
      scl_m = 1'b1;
      do @(negedge clk); while (!scl_line);
      wait_clk(HB);
      sda_m = 1'b0;
      wait_clk(HB);
      scl_m = 1'b0;
      wait_clk(HB/2);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0;
      wait_clk(HB);
      scl_m = 1'b1;
      do @(negedge clk); while (!scl_line);
      wait_clk(HB);
      sda_m = 1'b1;
      wait_clk(HB);
      if (e_engaged) e_stop = 1'b1;
      e_engaged = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bit_x(b[i], s);
      bit_x(1'b1, ack);
   endtask

   task automatic read_byte(input logic mack, output logic [7:0] b);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bit_x(1'b1, s);
         b[i] = s;
      end
      bit_x(mack, s);
   endtask

   // address phase with the bench's own match model
   task automatic addr_phase(input logic [7:0] b, input string req);
      logic ack;
      bit   hit_own, hit_gc;
      hit_own = tgt_en && (own != 7'd0) && (b[7:1] == own);
      hit_gc  = gc_en && (b == 8'h00);
      send_byte(b, ack);
      chk(req, "address ack (0=acked)", int'(ack), int'(!(hit_own || hit_gc)));
      if (hit_own || hit_gc) begin
         e_nm = 1'b1;
         e_engaged = 1'b1;
         if (hit_own) begin e_own = 1'b1; e_xmit = b[0]; end
         else begin e_gc = 1'b1; e_xmit = 1'b0; end
      end else begin
         e_engaged = 1'b0;
      end
      chk_flags(req);
   endtask

   task automatic write_data(input logic [7:0] b);
      logic ack;
      send_byte(b, ack);
      chk("R6", "data ack (0=acked)", int'(ack), 0);
      chk("R6", "rx_data", int'(rx_data), int'(b));
      chk("R6", "sdast after byte", int'(sdast), 1);
      chk("R6", "scl stretched", int'(scl_oe), 1);
      @(negedge clk) rx_take = 1'b1;
      @(negedge clk) rx_take = 1'b0;
      wait_clk(1);
      chk("R6", "sdast after take", int'(sdast), 0);
      chk("R6", "stretch released", int'(scl_oe), 0);
   endtask

   task automatic serve_tx(input logic [7:0] b, input logic mack);
      logic [7:0] got;
      chk("R7", "sdast while empty", int'(sdast), 1);
      chk("R7", "scl stretched", int'(scl_oe), 1);
      @(negedge clk) begin tx_data = b; tx_load = 1'b1; end
      @(negedge clk) tx_load = 1'b0;
      wait_clk(2);
      chk("R7", "stretch released", int'(scl_oe), 0);
      read_byte(mack, got);
      chk("R7", "transmitted byte", int'(got), int'(b));
      if (mack) begin
         e_nack = 1'b1;
         wait_clk(2);
         chk("R8", "nack_seen", int'(nack_seen), 1);
         chk("R8", "sda released", int'(sda_oe), 0);
      end
   endtask

   task automatic clear_all();
      @(negedge clk) begin clr_match = 1'b1; clr_stop = 1'b1; clr_nack = 1'b1; end
      @(negedge clk) begin clr_match = 1'b0; clr_stop = 1'b0; clr_nack = 1'b0; end
      e_nm = 0; e_own = 0; e_gc = 0; e_stop = 0; e_nack = 0;
      wait_clk(1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      wait_clk(5);
      // R1 reset state
      chk("R1", "new_match", int'(new_match), 0);
      chk("R1", "own_hit", int'(own_hit), 0);
      chk("R1", "gcall_hit", int'(gcall_hit), 0);
      chk("R1", "stop_seen", int'(stop_seen), 0);
      chk("R1", "nack_seen", int'(nack_seen), 0);
      chk("R1", "irq/sdast/xmit", int'({irq, sdast, xmit}), 0);
      chk("R1", "bus drivers", int'({scl_oe, sda_oe}), 0);
      rst_n = 1'b1;
      wait_clk(5);

      // R2 R6 R9: write to own address, two data bytes
      bus_start();
      addr_phase({7'h5A, 1'b0}, "R2");
      write_data(8'hC3);
      write_data(8'h3C);
      bus_stop();
      chk_flags("R9");
      chk("R9", "stop_seen set", int'(stop_seen), 1);

      // R5 clear and irq gating
      clear_all();
      chk_flags("R5");
      chk("R5", "irq after clear", int'(irq), 0);

      // R3 unmatched address, then STOP leaves stop_seen clear (R9)
      bus_start();
      addr_phase({7'h33, 1'b0}, "R3");
      bus_stop();
      chk("R9", "no stop flag without match", int'(stop_seen), 0);

      // R4 general call, enabled
      bus_start();
      addr_phase(8'h00, "R4");
      chk("R4", "xmit forced 0", int'(xmit), 0);
      write_data(8'hA5);
      bus_stop();
      clear_all();

      // R4 near miss 0x01, and gc disabled
      bus_start();
      addr_phase(8'h01, "R4");
      bus_stop();
      gc_en = 1'b0;
      bus_start();
      addr_phase(8'h00, "R4");
      bus_stop();
      gc_en = 1'b1;

      // R3 target disabled; R5 irq masked
      tgt_en = 1'b0;
      bus_start();
      addr_phase({7'h5A, 1'b0}, "R3");
      bus_stop();
      tgt_en = 1'b1;

      // R7 R8 transmit, ACK then NACK
      nm_ie = 1'b0;
      bus_start();
      addr_phase({7'h5A, 1'b1}, "R7");
      chk("R5", "irq masked", int'(irq), 0);
      nm_ie = 1'b1;
      wait_clk(1);
      chk("R5", "irq unmasked", int'(irq), 1);
      serve_tx(8'h96, 1'b0);
      serve_tx(8'h5E, 1'b1);
      bus_stop();
      chk_flags("R8");
      clear_all();
      chk("R8", "nack cleared", int'(nack_seen), 0);

      // R10 repeated START, receive then transmit
      bus_start();
      addr_phase({7'h5A, 1'b0}, "R10");
      write_data(8'h11);
      @(negedge clk) clr_match = 1'b1;
      @(negedge clk) clr_match = 1'b0;
      e_nm = 0; e_own = 0;
      wait_clk(1);
      bus_rep_start();
      chk("R10", "no stop on repeated start", int'(stop_seen), 0);
      addr_phase({7'h5A, 1'b1}, "R10");
      chk("R10", "direction now transmit", int'(xmit), 1);
      serve_tx(8'h42, 1'b1);
      bus_stop();
      chk_flags("R10");

      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule